// File: doc/BRIEF.md
# UART Loopback and Modem-Status Unit

This unit sits between a UART's register file and its receive buffer. It selects where the modem-status flags and the receive entries come from. In normal operation the four modem flags follow the external modem input pins, through a synchronizer. Externally received characters and line breaks pass through to the receive buffer.

When software sets the loopback bit in the control word, the path changes in four ways:
- The modem flags are taken from the control word's own modem outputs instead of the pins.
- Every byte written for transmission is pushed straight into the receive buffer.
- A rising break-enable bit injects a break entry into the receive buffer.
- The external receive stream is swallowed and discarded.

The modem interrupt bits are reloaded from the looped-back values on every control write that has loopback set. Software clears them one bit at a time.

The receive buffer is driven over a valid/ready push port. External characters arrive over a valid/ready port. Outside loopback, the unit is a combinational pass-through, so back-pressure from the buffer reaches the external source unchanged. Inside loopback, the external port is always ready and what it accepts is thrown away. Loopback entries come from register writes and cannot stall. A loopback entry is offered for exactly one cycle, and it is lost if the buffer is not ready in that cycle.

Top module: `lbm_loopback`

## Requirements
- R1: While loopback is on (control bit 7), status_flags bit 8 equals control bit 13, bit 2 equals control bit 12, bit 0 equals control bit 11 and bit 1 equals control bit 10. All other status_flags bits are 0.
- R2: A control write updates status_flags in the very next cycle. This also holds for a write that sets only the loopback bit, which forces every modem flag to 0 at once.
- R3: On a control write with bit 7 set, ms_irq is reloaded as {bit3 = RI, bit2 = DCD, bit1 = DSR, bit0 = CTS} from the looped-back values. A control write with bit 7 clear leaves ms_irq unchanged. Outside reloads, each ms_clr bit that is 1 clears the matching ms_irq bit, and ms_irq bits never rise.
- R4: With loopback off, status_flags follows the pins (RI at bit 8, DCD bit 2, DSR bit 1, CTS bit 0). A pin change appears after SYNC_STAGES clock edges (2 by default) and not before.
- R5: With loopback on, a tx_stb cycle offers push_data = tx_data zero-extended to 11 bits (bit 10 = 0) in that same cycle.
- R6: With loopback on, a 0-to-1 change of brk_en offers one entry with only bit 10 set, in the cycle after the change. The following are not pushed:
  - a 1-to-0 change of brk_en;
  - a rise while loopback is off.
  If tx_stb is high in the cycle the break is due, the byte goes first and the break entry follows in the next cycle.
- R7: With loopback on, ext_ready is 1 whatever push_ready is, and an external character or break pushes nothing.
- R8: With loopback off, push_valid and push_data follow ext_valid and the external entry, and ext_ready equals push_ready. An external break (ext_brk) gives an entry with only bit 10 set. tx_stb pushes nothing.
- R9: A loopback entry offered while push_ready is 0 is dropped and not offered again.
- R10: After reset, loopback is off and ms_irq is 0. status_flags and push_valid are 0 while the pins and ext_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control-word write strobe |
| ctrl_wdata | input | 16 | Control word (bit 7 loopback, 10 DTR, 11 RTS, 12 OUT1, 13 OUT2) |
| ms_clr | input | 4 | Write-one-to-clear for ms_irq |
| pin_ri | input | 1 | External ring-indicator pin |
| pin_dcd | input | 1 | External carrier-detect pin |
| pin_dsr | input | 1 | External data-set-ready pin |
| pin_cts | input | 1 | External clear-to-send pin |
| brk_en | input | 1 | Break-enable bit of the line control |
| tx_stb | input | 1 | Transmit byte written this cycle |
| tx_data | input | DATA_W | Transmitted byte |
| ext_valid | input | 1 | External receive entry valid |
| ext_data | input | DATA_W | External received byte |
| ext_brk | input | 1 | External entry is a line break |
| ext_ready | output | 1 | External entry accepted |
| push_valid | output | 1 | Receive-buffer push valid |
| push_data | output | 11 | Receive entry, bit 10 = break |
| push_ready | input | 1 | Receive buffer can accept |
| status_flags | output | 9 | Modem flags (RI 8, DCD 2, DSR 1, CTS 0) |
| ms_irq | output | 4 | Modem interrupt bits {RI, DCD, DSR, CTS} |

## Verification
The bench writes a control word that sets only the loopback bit while the pins hold non-zero flags. A design that applies the mapping lazily, or keeps the pin values, shows stale flags in the next cycle. It writes control words with loopback clear and checks that ms_irq keeps its value, which catches a reload on every write. It raises brk_en and drives a transmit strobe in the cycle the break is due, which exposes a design that loses the break, duplicates it, or lets it overwrite the byte. It also offers loopback entries against a stalled buffer and external entries during loopback, which catches retries and leaks of external data.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  localparam int CTRL_W   = 16;
  localparam int LB_BIT   = 7;
  localparam int DTR_BIT  = 10;
  localparam int RTS_BIT  = 11;
  localparam int OUT1_BIT = 12;
  localparam int OUT2_BIT = 13;

  localparam int FLAG_W = 9;
  localparam int F_CTS  = 0;
  localparam int F_DSR  = 1;
  localparam int F_DCD  = 2;
  localparam int F_RI   = 8;

  localparam int BRK_BIT = 10;
  localparam int ENTRY_W = BRK_BIT + 1;

  typedef struct packed {
    logic ri;
    logic dcd;
    logic dsr;
    logic cts;
  } modem_t;

  function automatic modem_t ctrl_to_modem(input logic [CTRL_W-1:0] w);
    modem_t m;
    m.ri  = w[OUT2_BIT];
    m.dcd = w[OUT1_BIT];
    m.cts = w[RTS_BIT];
    m.dsr = w[DTR_BIT];
    return m;
  endfunction

  function automatic logic [FLAG_W-1:0] modem_to_flags(input modem_t m);
    logic [FLAG_W-1:0] f;
    f        = '0;
    f[F_RI]  = m.ri;
    f[F_DCD] = m.dcd;
    f[F_DSR] = m.dsr;
    f[F_CTS] = m.cts;
    return f;
  endfunction
endpackage

// File: rtl/lbm_sync.sv
module lbm_sync
  import lbm_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  modem_t pins_i,
  output modem_t pins_o
);
  localparam int W = $bits(modem_t);

  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= pins_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign pins_o = modem_t'(stg_q[STAGES-1]);
endmodule

// File: rtl/lbm_ctrl.sv
module lbm_ctrl
  import lbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic [3:0]        ms_clr_i,
  input  modem_t            pins_i,
  output logic              lb_o,
  output logic [FLAG_W-1:0] flags_o,
  output modem_t            ms_irq_o
);
  logic   lb_q;
  modem_t loop_q;
  modem_t ms_q;
  logic   wdata_unused;

  assign wdata_unused = ^{ctrl_wdata_i[CTRL_W-1:OUT2_BIT+1],
                          ctrl_wdata_i[DTR_BIT-1:LB_BIT+1],
                          ctrl_wdata_i[LB_BIT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_q   <= 1'b0;
      loop_q <= '0;
    end else if (ctrl_wr_i) begin
      lb_q   <= ctrl_wdata_i[LB_BIT];
      loop_q <= ctrl_to_modem(ctrl_wdata_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q <= '0;
    end else if (ctrl_wr_i && ctrl_wdata_i[LB_BIT]) begin
      ms_q <= ctrl_to_modem(ctrl_wdata_i);
    end else begin
      ms_q <= modem_t'(ms_q & ~ms_clr_i);
    end
  end

  assign lb_o     = lb_q;
  assign flags_o  = lb_q ? modem_to_flags(loop_q) : modem_to_flags(pins_i);
  assign ms_irq_o = ms_q;

  // R3: a loopback write reloads the interrupt bits from the written outputs
  assert_irq_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && ctrl_wdata_i[LB_BIT]) |=>
      (ms_irq_o == ctrl_to_modem($past(ctrl_wdata_i))));

  // R3: without a loopback write no interrupt bit may rise
  assert_irq_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr_i && ctrl_wdata_i[LB_BIT]) |=>
      ((ms_irq_o & ~$past(ms_irq_o)) == 4'b0000));

  // R1 / R2: flags show the cross-wired outputs right after a loopback write
  assert_flag_cross_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && ctrl_wdata_i[LB_BIT]) |=>
      (flags_o[F_RI]  == $past(ctrl_wdata_i[OUT2_BIT]) &&
       flags_o[F_DCD] == $past(ctrl_wdata_i[OUT1_BIT]) &&
       flags_o[F_CTS] == $past(ctrl_wdata_i[RTS_BIT])  &&
       flags_o[F_DSR] == $past(ctrl_wdata_i[DTR_BIT])));
endmodule

// File: rtl/lbm_brk.sv
module lbm_brk (
  input  logic clk,
  input  logic rst_n,
  input  logic lb_i,
  input  logic brk_en_i,
  input  logic tx_stb_i,
  output logic pend_o
);
  logic prev_q;
  logic pend_q;
  logic rise;

  assign rise = brk_en_i & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= brk_en_i;
      pend_q <= lb_i & (rise | (pend_q & tx_stb_i));
    end
  end

  assign pend_o = pend_q;

  // R6: a break entry offered without a competing byte is gone next cycle
  assert_brk_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !tx_stb_i && !rise) |=> !pend_q);

  // R6: no break entry appears unless a rise was seen in loopback
  assert_brk_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(lb_i) && $past(brk_en_i)));
endmodule

// File: rtl/lbm_arb.sv
module lbm_arb
  import lbm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lb_i,
  input  logic               tx_stb_i,
  input  logic [DATA_W-1:0]  tx_data_i,
  input  logic               pend_i,
  input  logic               ext_valid_i,
  input  logic [DATA_W-1:0]  ext_data_i,
  input  logic               ext_brk_i,
  output logic               ext_ready_o,
  output logic               push_valid_o,
  output logic [ENTRY_W-1:0] push_data_o,
  input  logic               push_ready_i
);
  localparam int PAD_W = ENTRY_W - DATA_W;
  localparam logic [ENTRY_W-1:0] BRK_ENTRY = ENTRY_W'(1) << BRK_BIT;

  logic [ENTRY_W-1:0] tx_entry;
  logic [ENTRY_W-1:0] ext_entry;

  assign tx_entry  = {{PAD_W{1'b0}}, tx_data_i};
  assign ext_entry = ext_brk_i ? BRK_ENTRY : {{PAD_W{1'b0}}, ext_data_i};

  always_comb begin
    if (lb_i) begin
      ext_ready_o  = 1'b1;
      push_valid_o = tx_stb_i | pend_i;
      push_data_o  = tx_stb_i ? tx_entry : BRK_ENTRY;
    end else begin
      ext_ready_o  = push_ready_i;
      push_valid_o = ext_valid_i;
      push_data_o  = ext_entry;
    end
  end

  // R7: loopback never back-pressures the external source
  assert_ext_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lb_i |-> ext_ready_o);

  // R7: external traffic cannot reach the buffer during loopback
  assert_ext_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_i && !tx_stb_i && !pend_i) |-> !push_valid_o);

  // R8: transmit strobes stay out of the buffer outside loopback
  assert_tx_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_i && !ext_valid_i) |-> !push_valid_o);
endmodule

// File: rtl/lbm_loopback.sv
module lbm_loopback
  import lbm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr,
  input  logic [CTRL_W-1:0]  ctrl_wdata,
  input  logic [3:0]         ms_clr,
  input  logic               pin_ri,
  input  logic               pin_dcd,
  input  logic               pin_dsr,
  input  logic               pin_cts,
  input  logic               brk_en,
  input  logic               tx_stb,
  input  logic [DATA_W-1:0]  tx_data,
  input  logic               ext_valid,
  input  logic [DATA_W-1:0]  ext_data,
  input  logic               ext_brk,
  output logic               ext_ready,
  output logic               push_valid,
  output logic [ENTRY_W-1:0] push_data,
  input  logic               push_ready,
  output logic [FLAG_W-1:0]  status_flags,
  output logic [3:0]         ms_irq
);
  modem_t pins_raw;
  modem_t pins_sync;
  modem_t ms_irq_s;
  logic   lb;
  logic   brk_pend;

  assign pins_raw = '{ri: pin_ri, dcd: pin_dcd, dsr: pin_dsr, cts: pin_cts};

  lbm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_i (pins_raw),
    .pins_o (pins_sync)
  );

  lbm_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr_i    (ctrl_wr),
    .ctrl_wdata_i (ctrl_wdata),
    .ms_clr_i     (ms_clr),
    .pins_i       (pins_sync),
    .lb_o         (lb),
    .flags_o      (status_flags),
    .ms_irq_o     (ms_irq_s)
  );

  lbm_brk u_brk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lb_i     (lb),
    .brk_en_i (brk_en),
    .tx_stb_i (tx_stb),
    .pend_o   (brk_pend)
  );

  lbm_arb #(.DATA_W(DATA_W)) u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .lb_i         (lb),
    .tx_stb_i     (tx_stb),
    .tx_data_i    (tx_data),
    .pend_i       (brk_pend),
    .ext_valid_i  (ext_valid),
    .ext_data_i   (ext_data),
    .ext_brk_i    (ext_brk),
    .ext_ready_o  (ext_ready),
    .push_valid_o (push_valid),
    .push_data_o  (push_data),
    .push_ready_i (push_ready)
  );

  assign ms_irq = ms_irq_s;

  // R9: a loopback byte is offered only in its own strobe cycle, never retried
  assert_no_retry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lb && push_valid && !push_ready && !brk_pend && !tx_stb) |-> 1'b0);
endmodule

// File: tb/lbm_loopback_bench.sv
module lbm_loopback_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [3:0]  ms_clr = '0;
  logic        pin_ri = 0, pin_dcd = 0, pin_dsr = 0, pin_cts = 0;
  logic        brk_en = 0, tx_stb = 0;
  logic [7:0]  tx_data = '0;
  logic        ext_valid = 0, ext_brk = 0;
  logic [7:0]  ext_data = '0;
  logic        ext_ready, push_valid, push_ready = 1'b1;
  logic [10:0] push_data;
  logic [8:0]  status_flags;
  logic [3:0]  ms_irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbm_loopback u_lbm_loopback (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ms_clr(ms_clr), .pin_ri(pin_ri), .pin_dcd(pin_dcd), .pin_dsr(pin_dsr),
    .pin_cts(pin_cts), .brk_en(brk_en), .tx_stb(tx_stb), .tx_data(tx_data),
    .ext_valid(ext_valid), .ext_data(ext_data), .ext_brk(ext_brk),
    .ext_ready(ext_ready), .push_valid(push_valid), .push_data(push_data),
    .push_ready(push_ready), .status_flags(status_flags), .ms_irq(ms_irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // advance one edge and settle just after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_ctrl(input logic [15:0] w);
    ctrl_wdata = w;
    ctrl_wr = 1'b1;
    step();
    ctrl_wr = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R10", "flags after reset", status_flags, 0);
    chk("R10", "ms_irq after reset", ms_irq, 0);
    chk("R10", "push_valid after reset", push_valid, 0);
  endtask

  task automatic t_pins_follow();
    pin_ri = 1; pin_dsr = 1;
    step();
    chk("R4", "flags after one edge", status_flags, 9'h000);
    step();
    chk("R4", "flags after two edges", status_flags, 9'h102);
  endtask

  task automatic t_loop_map();
    wr_ctrl(16'h0080);
    chk("R2", "loopback-only write clears flags", status_flags, 9'h000);
    chk("R3", "ms_irq after loopback-only write", ms_irq, 4'b0000);
    wr_ctrl(16'h2880);
    chk("R1", "OUT2+RTS flags", status_flags, 9'h101);
    chk("R3", "OUT2+RTS ms_irq", ms_irq, 4'b1001);
    wr_ctrl(16'h1480);
    chk("R1", "OUT1+DTR flags", status_flags, 9'h006);
    chk("R3", "OUT1+DTR ms_irq", ms_irq, 4'b0110);
  endtask

  task automatic t_irq_clear();
    ms_clr = 4'b0010;
    step();
    ms_clr = 4'b0000;
    #1;
    chk("R3", "ms_irq after clearing DSR", ms_irq, 4'b0100);
    wr_ctrl(16'h3C00);
    chk("R3", "non-loopback write keeps ms_irq", ms_irq, 4'b0100);
    chk("R4", "flags back to pins", status_flags, 9'h102);
  endtask

  task automatic t_tx_loop();
    wr_ctrl(16'h0080);
    push_ready = 1;
    tx_stb = 1; tx_data = 8'hA5;
    #1;
    chk("R5", "tx push_valid", push_valid, 1);
    chk("R5", "tx push_data", push_data, 11'h0A5);
    step();
    tx_stb = 0;
    #1;
    chk("R5", "no push after strobe", push_valid, 0);
  endtask

  task automatic t_drop();
    push_ready = 0;
    tx_stb = 1; tx_data = 8'h3C;
    #1;
    chk("R9", "offered while stalled", push_data, 11'h03C);
    step();
    tx_stb = 0;
    #1;
    chk("R9", "not offered again", push_valid, 0);
    push_ready = 1;
  endtask

  task automatic t_ext_block();
    push_ready = 0;
    ext_valid = 1; ext_data = 8'h77; ext_brk = 1;
    #1;
    chk("R7", "ext_ready in loopback", ext_ready, 1);
    chk("R7", "ext not pushed", push_valid, 0);
    step();
    ext_valid = 0; ext_brk = 0; push_ready = 1;
    #1;
  endtask

  task automatic t_brk_loop();
    brk_en = 1;
    #1;
    chk("R6", "no break same cycle", push_valid, 0);
    step();
    chk("R6", "break offered", push_valid, 1);
    chk("R6", "break entry", push_data, 11'h400);
    step();
    chk("R6", "break offered once", push_valid, 0);
    brk_en = 0;
    step();
    chk("R6", "falling break no push", push_valid, 0);
    step();
    chk("R6", "falling break no push later", push_valid, 0);
    // break due in the same cycle as a byte
    brk_en = 1;
    step();
    tx_stb = 1; tx_data = 8'h5A;
    #1;
    chk("R6", "byte wins over break", push_data, 11'h05A);
    step();
    tx_stb = 0;
    #1;
    chk("R6", "break follows byte valid", push_valid, 1);
    chk("R6", "break follows byte data", push_data, 11'h400);
    step();
    chk("R6", "break gone after delivery", push_valid, 0);
    brk_en = 0;
    step();
  endtask

  task automatic t_brk_outside();
    wr_ctrl(16'h0000);
    brk_en = 1;
    step();
    chk("R6", "break outside loopback", push_valid, 0);
    step();
    chk("R6", "break outside loopback later", push_valid, 0);
    brk_en = 0;
    step();
  endtask

  task automatic t_ext_pass();
    push_ready = 0;
    ext_valid = 1; ext_data = 8'h31;
    #1;
    chk("R8", "ext valid passes", push_valid, 1);
    chk("R8", "ext data passes", push_data, 11'h031);
    chk("R8", "ext_ready follows stall", ext_ready, 0);
    push_ready = 1;
    #1;
    chk("R8", "ext_ready follows ready", ext_ready, 1);
    ext_brk = 1;
    #1;
    chk("R8", "ext break entry", push_data, 11'h400);
    ext_valid = 0; ext_brk = 0;
    tx_stb = 1; tx_data = 8'h99;
    #1;
    chk("R8", "tx not pushed outside loopback", push_valid, 0);
    step();
    tx_stb = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_pins_follow();
    t_loop_map();
    t_irq_clear();
    t_tx_loop();
    t_drop();
    t_ext_block();
    t_brk_loop();
    t_brk_outside();
    t_ext_pass();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule